// File: doc/BRIEF.md
# Switch Ingress Frame Admission Filter

This block sits on one receive port of a five-port store-and-forward switch. When a frame has been fully received, it takes the end-of-frame status, the egress port mask from the address lookup, and the per-port configuration. From these it decides whether the frame may leave the switch and, if so, on which ports.

The decision is made in two stages:

- **First stage.** The block rejects the frame if it is malformed, has an illegal size, is a flow-control pause frame, or is addressed only back to its own port. Otherwise the lookup mask becomes the first-stage mask.
- **Second stage.** The block trims that mask by spanning-tree forwarding state and VLAN membership. It then adds the sniffer port when mirroring applies, and finally clears the receiving port.

The result is registered and presented with a one-cycle valid pulse. A separate pulse tells the local flow-control logic that a good pause frame was taken.

Top module: `ingress_admit_filter`

## Requirements
- R1: A frame flagged with a framing, FCS or alignment error gets an all-zero egress mask.
- R2: A frame shorter than 64 bytes gets an all-zero egress mask; a frame of exactly 64 bytes is admitted.
- R3: With `long_frames` low the longest admitted untagged frame is 1536 bytes; with it high the longest is 1916 bytes. One byte more gives an all-zero mask.
- R4: When `tag_present` is high, each maximum in R3 grows by exactly 4 bytes (1540 or 1920).
- R5: A frame with `is_pause` high always gets an all-zero mask. When it carries no error flag, `pause_seen` pulses for one cycle together with `dec_valid`.
- R6: A frame whose lookup mask has exactly one bit set, the bit of `ingress_port`, is local and gets an all-zero mask.
- R7: For an admitted frame, the egress mask is the lookup mask ANDed with `stp_fwd` and with `vlan_member`. Bit i of each mask stands for port i. The sniffer bit may additionally be set by R9.
- R8: The bit of `ingress_port` is always zero in the egress mask, even when the lookup mask or the sniffer selection names it.
- R9: When `mirror_en` is high and either `mirror_rx[ingress_port]` is set or `mirror_tx` overlaps the mask of R7, bit `sniffer_port` is added to the mask of an admitted frame. Neither spanning-tree state nor VLAN membership filters this bit.
- R10: `dec_valid` is high exactly in the cycle after a cycle with `eof_valid` high. `fwd_mask` and `drop` change only on that edge, and `drop` is high exactly when `fwd_mask` is zero.
- R11: After reset `dec_valid` and `pause_seen` are low, `fwd_mask` is zero and `drop` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eof_valid | input | 1 | End-of-frame strobe; status inputs valid this cycle |
| err_framing | input | 1 | Framing error flag |
| err_fcs | input | 1 | FCS error flag |
| err_align | input | 1 | Alignment error flag |
| frame_len | input | LEN_W | Frame length in bytes |
| tag_present | input | 1 | Frame carries a VLAN tag |
| is_pause | input | 1 | Frame is an 802.3x pause frame |
| lookup_mask | input | NPORTS | Destination lookup result, one bit per port |
| ingress_port | input | PORT_W | Number of the receiving port |
| long_frames | input | 1 | Select the larger maximum frame size |
| stp_fwd | input | NPORTS | Spanning-tree forwarding enable per port |
| vlan_member | input | NPORTS | VLAN membership per port |
| mirror_en | input | 1 | Mirroring enable |
| mirror_rx | input | NPORTS | Ports whose received traffic is mirrored |
| mirror_tx | input | NPORTS | Ports whose transmitted traffic is mirrored |
| sniffer_port | input | PORT_W | Port receiving mirrored copies |
| dec_valid | output | 1 | Decision valid pulse |
| fwd_mask | output | NPORTS | Final egress port mask |
| drop | output | 1 | Frame forwarded nowhere |
| pause_seen | output | 1 | Good pause frame taken for local flow control |

## Verification
The assertions look one cycle back at the status, lookup and configuration inputs. They therefore take for granted that those inputs are stable and meaningful in the cycle `eof_valid` is high. They also assume `ingress_port` and `sniffer_port` are below the port count. The stimulus drives every input on the falling edge and holds it across the strobe cycle. It only ever uses port numbers 0 to 4, so the shifted port bits always land inside the mask.

// File: rtl/ingress_admit_filter.sv
module ingress_admit_filter #(
  parameter int NPORTS    = 5,
  parameter int PORT_W    = $clog2(NPORTS),
  parameter int LEN_W     = 11,
  parameter int MIN_LEN   = 64,
  parameter int STD_MAX   = 1536,
  parameter int LONG_MAX  = 1916,
  parameter int TAG_EXTRA = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eof_valid,
  input  logic              err_framing,
  input  logic              err_fcs,
  input  logic              err_align,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              tag_present,
  input  logic              is_pause,
  input  logic [NPORTS-1:0] lookup_mask,
  input  logic [PORT_W-1:0] ingress_port,
  input  logic              long_frames,
  input  logic [NPORTS-1:0] stp_fwd,
  input  logic [NPORTS-1:0] vlan_member,
  input  logic              mirror_en,
  input  logic [NPORTS-1:0] mirror_rx,
  input  logic [NPORTS-1:0] mirror_tx,
  input  logic [PORT_W-1:0] sniffer_port,
  output logic              dec_valid,
  output logic [NPORTS-1:0] fwd_mask,
  output logic              drop,
  output logic              pause_seen
);
  localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] STD_L  = LEN_W'(STD_MAX);
  localparam logic [LEN_W-1:0] LONG_L = LEN_W'(LONG_MAX);
  localparam logic [LEN_W-1:0] TAG_L  = LEN_W'(TAG_EXTRA);

  logic [NPORTS-1:0] in_bit, sniff_bit, filtered, stage1, stage2;
  logic [LEN_W-1:0]  max_len;
  logic              bad_frame, bad_size, is_local, admit, mirror_hit;

  assign in_bit    = NPORTS'(1) << ingress_port;
  assign sniff_bit = NPORTS'(1) << sniffer_port;
  assign bad_frame = err_framing | err_fcs | err_align;
  assign max_len   = (long_frames ? LONG_L : STD_L) + (tag_present ? TAG_L : '0);
  assign bad_size  = (frame_len < MIN_L) || (frame_len > max_len);
  assign is_local  = (lookup_mask == in_bit);
  assign admit     = !bad_frame && !bad_size && !is_pause && !is_local;

  assign stage1     = lookup_mask;
  assign filtered   = stage1 & stp_fwd & vlan_member & ~in_bit;
  assign mirror_hit = mirror_en && ((|(mirror_rx & in_bit)) || (|(mirror_tx & filtered)));
  assign stage2     = (filtered | (mirror_hit ? sniff_bit : '0)) & ~in_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      pause_seen <= 1'b0;
      fwd_mask   <= '0;
    end else begin
      dec_valid  <= eof_valid;
      pause_seen <= eof_valid && is_pause && !bad_frame;
      if (eof_valid) fwd_mask <= admit ? stage2 : '0;
    end
  end

  assign drop = (fwd_mask == '0);

  assert_err_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && $past(err_framing | err_fcs | err_align) |-> fwd_mask == '0);

  assert_runt_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && ($past(frame_len) < MIN_L) |-> fwd_mask == '0);

  assert_pause_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pause_seen |-> dec_valid && fwd_mask == '0);

  assert_local_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && ($past(lookup_mask) == (NPORTS'(1) << $past(ingress_port))) |-> fwd_mask == '0);

  assert_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (fwd_mask & ~($past(stp_fwd & vlan_member & lookup_mask) |
                                (NPORTS'(1) << $past(sniffer_port)))) == '0);

  assert_ingress_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (fwd_mask & (NPORTS'(1) << $past(ingress_port))) == '0);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(eof_valid));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> $stable(fwd_mask));
endmodule

// File: tb/test_ingress_admit_filter.sv
module test_ingress_admit_filter;
  localparam int NP = 5;
  logic clk = 0, rst_n = 0;
  logic eof_valid = 0, err_framing = 0, err_fcs = 0, err_align = 0;
  logic [10:0] frame_len = 11'd100;
  logic tag_present = 0, is_pause = 0, long_frames = 0, mirror_en = 0;
  logic [NP-1:0] lookup_mask = '0, stp_fwd = '1, vlan_member = '1, mirror_rx = '0, mirror_tx = '0;
  logic [2:0] ingress_port = 0, sniffer_port = 4;
  logic dec_valid, drop, pause_seen;
  logic [NP-1:0] fwd_mask;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_tag = "R11", exp_tag = "R11";
  logic exp_valid = 0, exp_pause = 0;
  logic [NP-1:0] exp_mask = '0;

  always #2.5 clk = ~clk;

  ingress_admit_filter i_ingress_admit_filter (
    .clk(clk), .rst_n(rst_n), .eof_valid(eof_valid), .err_framing(err_framing),
    .err_fcs(err_fcs), .err_align(err_align), .frame_len(frame_len),
    .tag_present(tag_present), .is_pause(is_pause), .lookup_mask(lookup_mask),
    .ingress_port(ingress_port), .long_frames(long_frames), .stp_fwd(stp_fwd),
    .vlan_member(vlan_member), .mirror_en(mirror_en), .mirror_rx(mirror_rx),
    .mirror_tx(mirror_tx), .sniffer_port(sniffer_port), .dec_valid(dec_valid),
    .fwd_mask(fwd_mask), .drop(drop), .pause_seen(pause_seen));

  function automatic logic [NP-1:0] model_mask();
    int limit;
    bit errs, hit;
    logic [NP-1:0] m;
    int nset;
    errs  = err_framing || err_fcs || err_align;
    limit = (long_frames ? 1916 : 1536) + (tag_present ? 4 : 0);
    if (errs || int'(frame_len) < 64 || int'(frame_len) > limit || is_pause) return '0;
    nset = 0;
    for (int p = 0; p < NP; p++) if (lookup_mask[p]) nset++;
    if (nset == 1 && lookup_mask[ingress_port]) return '0;
    m = '0;
    hit = mirror_en && mirror_rx[ingress_port];
    for (int p = 0; p < NP; p++) begin
      if (lookup_mask[p] && stp_fwd[p] && vlan_member[p] && p != int'(ingress_port)) begin
        m[p] = 1'b1;
        if (mirror_en && mirror_tx[p]) hit = 1;
      end
    end
    if (hit && sniffer_port != ingress_port) m[sniffer_port] = 1'b1;
    return m;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid = 0; exp_pause = 0; exp_mask = '0; exp_tag = "R11";
    end else begin
      exp_valid = eof_valid;
      exp_pause = eof_valid && is_pause && !(err_framing || err_fcs || err_align);
      if (eof_valid) begin
        exp_mask = model_mask();
        exp_tag = cur_tag;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (dec_valid !== exp_valid || fwd_mask !== exp_mask || drop !== (exp_mask == '0) ||
          pause_seen !== exp_pause) begin
        errors++;
        $display("FAIL %s (R10 timing): valid=%b mask=%b drop=%b pause=%b expected valid=%b mask=%b drop=%b pause=%b",
                 exp_tag, dec_valid, fwd_mask, drop, pause_seen, exp_valid, exp_mask,
                 exp_mask == '0, exp_pause);
      end
    end
  end

  task automatic frame(input string tag);
    @(negedge clk);
    cur_tag = tag;
    eof_valid = 1;
    @(negedge clk);
    eof_valid = 0;
    err_framing = 0; err_fcs = 0; err_align = 0; is_pause = 0;
    @(negedge clk);
  endtask

  task automatic clean();
    frame_len = 11'd200; tag_present = 0; long_frames = 0;
    lookup_mask = 5'b00110; ingress_port = 0; stp_fwd = '1; vlan_member = '1;
    mirror_en = 0; mirror_rx = '0; mirror_tx = '0; sniffer_port = 4;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (dec_valid !== 0 || pause_seen !== 0 || fwd_mask !== '0 || drop !== 1) begin
      errors++;
      $display("FAIL R11: valid=%b pause=%b mask=%b drop=%b expected 0 0 00000 1",
               dec_valid, pause_seen, fwd_mask, drop);
    end
    rst_n = 1;
    clean();
    frame("R7 plain");
    err_framing = 1; frame("R1 framing");
    err_fcs = 1;     frame("R1 fcs");
    err_align = 1;   frame("R1 align");
    frame_len = 63;  frame("R2 runt 63");
    frame_len = 64;  frame("R2 min 64");
    frame_len = 1536; frame("R3 std max");
    frame_len = 1537; frame("R3 std over");
    long_frames = 1; frame_len = 1916; frame("R3 long max");
    frame_len = 1917; frame("R3 long over");
    tag_present = 1; frame_len = 1920; frame("R4 long tagged max");
    frame_len = 1921; frame("R4 long tagged over");
    long_frames = 0; frame_len = 1540; frame("R4 std tagged max");
    frame_len = 1541; frame("R4 std tagged over");
    clean();
    is_pause = 1; frame("R5 pause");
    is_pause = 1; err_fcs = 1; frame("R5 pause with error");
    ingress_port = 2; lookup_mask = 5'b00100; frame("R6 local");
    lookup_mask = 5'b01100; frame("R8 ingress in lookup");
    lookup_mask = 5'b11011; stp_fwd = 5'b10111; frame("R7 stp block");
    vlan_member = 5'b01111; frame("R7 vlan block");
    clean();
    mirror_en = 1; mirror_rx = 5'b00001; lookup_mask = 5'b00010; frame("R9 rx mirror");
    mirror_rx = '0; mirror_tx = 5'b00100; lookup_mask = 5'b00100; frame("R9 tx mirror");
    stp_fwd = 5'b11011; frame("R9 tx mirror port blocked");
    mirror_en = 0; stp_fwd = '1; frame("R9 mirror off");
    mirror_en = 1; mirror_rx = 5'b00001; sniffer_port = 0; frame("R8 sniffer is ingress");
    clean(); sniffer_port = 3; mirror_en = 1; mirror_rx = 5'b00001;
    stp_fwd = 5'b10111; vlan_member = 5'b10111; frame("R9 sniffer bypasses filters");
    clean();
    @(negedge clk); cur_tag = "R10 back-to-back"; eof_valid = 1; lookup_mask = 5'b01000;
    @(negedge clk); lookup_mask = 5'b10000;
    @(negedge clk); eof_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule